// File: doc/BRIEF.md
# Scaled-Index Effective Address Generator

This block forms a 32-bit memory address of the form base + scale·index + displacement from operand fields that an instruction decoder has already split out. It reads two values from an 8-entry, 32-bit register file through two combinational read ports. It scales the index value by 1, 2, 4 or 8. It builds the displacement from up to four little-endian bytes, sign-extending the short forms. The three terms are added modulo 2^32, and the result is held in a single output register stage.

A special register ID means "no register" and removes its term from the sum. This one encoding covers base-only, index-only and displacement-only forms. An index of the stack pointer, or any ID above the no-register value, is an illegal encoding. It is flagged on the output and the address is forced to zero.

Both sides use a valid/ready stream handshake. An operand set is taken on a clock edge where `in_valid` and `in_ready` are both high. The result shows on `out_valid` one cycle later. While `out_valid` is high and `out_ready` is low, the output holds and `in_ready` drops, so back-pressure passes straight upstream. When the consumer takes the result, a new operand set can be taken on the same edge.

Top module: `ea_gen_top`

## Requirements
- R1: For legal encodings, one cycle after acceptance `out_ea` = base term + (index term << scale) + displacement, modulo 2^32. A term is the register file word addressed by the ID.
- R2: `in_scale` code 0, 1, 2 or 3 multiplies the index term by 1, 2, 4 or 8.
- R3: `in_disp` carries displacement byte k in bits [8k+7:8k], with byte 0 least significant. `in_disp_len` code 0 means no displacement. Code 1 uses byte 0, sign-extended. Code 2 uses bytes 0–1, sign-extended. Code 3 uses all four bytes.
- R4: Register ID 8 in either field contributes zero to the sum and is legal.
- R5: Index ID 4 (stack pointer) sets `out_illegal` and forces `out_ea` to 0. Base ID 4 is legal.
- R6: Any ID from 9 to 15 in either field sets `out_illegal` and forces `out_ea` to 0.
- R7: `out_valid` rises on the clock edge after an accepted input. After reset, `out_valid` is 0.
- R8: While `out_valid` is high and `out_ready` is low, `out_ea` and `out_illegal` hold and `in_ready` is low. `in_ready` is high whenever the output stage is empty or being drained.
- R9: IDs 0–7 drive their low three bits onto the read-address ports. The base ID drives `rf_base_addr` and the index ID drives `rf_index_addr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operand set is valid |
| in_ready | output | 1 | Block can take an operand set |
| in_base_id | input | 4 | Base register ID (8 = none) |
| in_index_id | input | 4 | Index register ID (8 = none, 4 illegal) |
| in_scale | input | 2 | Scale code, shift 0–3 |
| in_disp | input | 32 | Displacement bytes, little-endian |
| in_disp_len | input | 2 | Displacement length code |
| rf_base_addr | output | 3 | Register file read address for base |
| rf_base_data | input | 32 | Register file read data for base |
| rf_index_addr | output | 3 | Register file read address for index |
| rf_index_data | input | 32 | Register file read data for index |
| out_valid | output | 1 | Result is valid |
| out_ready | input | 1 | Consumer takes the result |
| out_ea | output | 32 | Effective address |
| out_illegal | output | 1 | Operand encoding was illegal |

## Verification
The bench tests each scale code with a known index. A design that shifts in the wrong direction, or by the wrong amount, gives a clearly different address. It drives 1- and 2-byte displacements with the top bit set. A design that zero-extends, or puts the bytes in big-endian order, gives a wrong address. It also checks the no-register ID in each field, and a stack-pointer index next to a stack-pointer base, to catch decoders that drop the wrong term or flag the wrong field. It adds sums that wrap past 2^32. It ends with a stalled consumer while a second operand set waits. A design that overwrites the held result, or loses the waiting set, fails there.

// File: rtl/ea_pkg.sv
package ea_pkg;
  typedef enum logic [1:0] {
    DLEN_NONE = 2'd0,
    DLEN_B1   = 2'd1,
    DLEN_B2   = 2'd2,
    DLEN_B4   = 2'd3
  } disp_len_e;
endpackage

// File: rtl/ea_regdec.sv
module ea_regdec #(
  parameter int ID_W    = 4,
  parameter int NREG    = 8,
  parameter int NONE_ID = 8,
  localparam int RF_AW  = $clog2(NREG)
) (
  input  logic [ID_W-1:0]  id,
  output logic [RF_AW-1:0] rf_addr,
  output logic             present,
  output logic             bad
);
  logic is_none;

  always_comb begin
    present = (int'(id) < NREG);
    is_none = (int'(id) == NONE_ID);
    bad     = !present && !is_none;
    rf_addr = present ? id[RF_AW-1:0] : '0;
  end
endmodule

// File: rtl/ea_disp.sv
module ea_disp #(
  parameter int ADDR_W = 32,
  localparam int NB    = ADDR_W / 8
) (
  input  logic [ADDR_W-1:0] raw,
  input  ea_pkg::disp_len_e len,
  output logic [ADDR_W-1:0] disp
);
  logic [7:0] bytes [NB];

  genvar k;
  generate
    for (k = 0; k < NB; k++) begin : g_byte
      assign bytes[k] = raw[8*k +: 8];
    end
  endgenerate

  logic [ADDR_W-1:0] full_word;
  always_comb begin
    full_word = '0;
    for (int j = 0; j < NB; j++) full_word[8*j +: 8] = bytes[j];
  end

  always_comb begin
    unique case (len)
      ea_pkg::DLEN_NONE: disp = '0;
      ea_pkg::DLEN_B1:   disp = {{(ADDR_W-8){bytes[0][7]}}, bytes[0]};
      ea_pkg::DLEN_B2:   disp = {{(ADDR_W-16){bytes[1][7]}}, bytes[1], bytes[0]};
      default:           disp = full_word;
    endcase
  end
endmodule

// File: rtl/ea_scaler.sv
module ea_scaler #(
  parameter int ADDR_W  = 32,
  parameter int SCALE_W = 2,
  localparam int NSHIFT = 1 << SCALE_W
) (
  input  logic [ADDR_W-1:0]  value,
  input  logic [SCALE_W-1:0] scale,
  output logic [ADDR_W-1:0] scaled
);
  logic [ADDR_W-1:0] opt [NSHIFT];

  genvar s;
  generate
    for (s = 0; s < NSHIFT; s++) begin : g_shift
      assign opt[s] = value << s;
    end
  endgenerate

  assign scaled = opt[scale];
endmodule

// File: rtl/ea_gen_top.sv
module ea_gen_top #(
  parameter int ADDR_W  = 32,
  parameter int ID_W    = 4,
  parameter int NREG    = 8,
  parameter int NONE_ID = 8,
  parameter int SP_ID   = 4,
  parameter int SCALE_W = 2,
  localparam int RF_AW  = $clog2(NREG)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid,
  output logic               in_ready,
  input  logic [ID_W-1:0]    in_base_id,
  input  logic [ID_W-1:0]    in_index_id,
  input  logic [SCALE_W-1:0] in_scale,
  input  logic [ADDR_W-1:0]  in_disp,
  input  logic [1:0]         in_disp_len,
  output logic [RF_AW-1:0]   rf_base_addr,
  input  logic [ADDR_W-1:0]  rf_base_data,
  output logic [RF_AW-1:0]   rf_index_addr,
  input  logic [ADDR_W-1:0]  rf_index_data,
  output logic               out_valid,
  input  logic               out_ready,
  output logic [ADDR_W-1:0]  out_ea,
  output logic               out_illegal
);
  logic base_present, base_bad, idx_present, idx_bad;

  ea_regdec #(.ID_W(ID_W), .NREG(NREG), .NONE_ID(NONE_ID)) i_dec_base (
    .id(in_base_id), .rf_addr(rf_base_addr),
    .present(base_present), .bad(base_bad));

  ea_regdec #(.ID_W(ID_W), .NREG(NREG), .NONE_ID(NONE_ID)) i_dec_index (
    .id(in_index_id), .rf_addr(rf_index_addr),
    .present(idx_present), .bad(idx_bad));

  logic [ADDR_W-1:0] disp_ext;
  ea_disp #(.ADDR_W(ADDR_W)) i_disp (
    .raw(in_disp), .len(ea_pkg::disp_len_e'(in_disp_len)), .disp(disp_ext));

  logic [ADDR_W-1:0] idx_term, idx_scaled, base_term;
  assign idx_term  = idx_present  ? rf_index_data : '0;
  assign base_term = base_present ? rf_base_data  : '0;

  ea_scaler #(.ADDR_W(ADDR_W), .SCALE_W(SCALE_W)) i_scale (
    .value(idx_term), .scale(in_scale), .scaled(idx_scaled));

  logic              sp_index, illegal_c;
  logic [ADDR_W-1:0] ea_c;
  always_comb begin
    sp_index  = (int'(in_index_id) == SP_ID);
    illegal_c = base_bad || idx_bad || sp_index;
    ea_c      = illegal_c ? '0 : (base_term + idx_scaled + disp_ext);
  end

  // single output stage with stream handshake
  logic accept;
  assign in_ready = !out_valid || out_ready;
  assign accept   = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid   <= 1'b0;
      out_ea      <= '0;
      out_illegal <= 1'b0;
    end else begin
      if (accept) begin
        out_ea      <= ea_c;
        out_illegal <= illegal_c;
      end
      if (accept) out_valid <= 1'b1;
      else if (out_ready) out_valid <= 1'b0;
    end
  end

  // R7: accepted input gives valid output next cycle
  p_latency_r7: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> out_valid);

  // R8: stalled output holds its payload
  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_ea) && $stable(out_illegal));

  // R8: no acceptance while stalled
  p_stall_r8: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |-> !in_ready);

  // R5: stack pointer as index flagged
  p_sp_index_r5: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && int'(in_index_id) == SP_ID |=> out_illegal && out_ea == '0);

  // R6: illegal result carries a zero address
  p_illegal_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_illegal |-> out_ea == '0);

  // R4: both registers absent, no displacement gives zero, legal
  p_none_r4: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && int'(in_base_id) == NONE_ID && int'(in_index_id) == NONE_ID
      && in_disp_len == 2'd0 |=> out_ea == '0 && !out_illegal);

  // R3: one-byte displacement alone is sign-extended
  p_sext_r3: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && int'(in_base_id) == NONE_ID && int'(in_index_id) == NONE_ID
      && in_disp_len == 2'd1
      |=> out_ea == {{(ADDR_W-8){$past(in_disp[7])}}, $past(in_disp[7:0])});
endmodule

// File: tb/test_ea_gen_top.sv
module test_ea_gen_top;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        in_valid = 0, in_ready;
  logic [3:0]  in_base_id = 8, in_index_id = 8;
  logic [1:0]  in_scale = 0, in_disp_len = 0;
  logic [31:0] in_disp = 0;
  logic [2:0]  rf_base_addr, rf_index_addr;
  logic [31:0] rf_base_data, rf_index_data;
  logic        out_valid, out_ready = 1;
  logic [31:0] out_ea;
  logic        out_illegal;

  logic [31:0] rf [8];
  int n_chk = 0, n_bad = 0, cycles = 0;

  always #5 clk = ~clk;

  assign rf_base_data  = rf[rf_base_addr];
  assign rf_index_data = rf[rf_index_addr];

  ea_gen_top i_ea_gen_top (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_base_id(in_base_id), .in_index_id(in_index_id), .in_scale(in_scale),
    .in_disp(in_disp), .in_disp_len(in_disp_len),
    .rf_base_addr(rf_base_addr), .rf_base_data(rf_base_data),
    .rf_index_addr(rf_index_addr), .rf_index_data(rf_index_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_ea(out_ea),
    .out_illegal(out_illegal));

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] dext(logic [1:0] len, logic [31:0] raw);
    case (len)
      2'd0: return 32'd0;
      2'd1: return {{24{raw[7]}}, raw[7:0]};
      2'd2: return {{16{raw[15]}}, raw[15:0]};
      default: return raw;
    endcase
  endfunction

  function automatic logic [32:0] model(logic [3:0] b, logic [3:0] i,
                                        logic [1:0] s, logic [1:0] l, logic [31:0] d);
    logic [31:0] bt, it;
    if (b > 8 || i > 8 || i == 4) return {1'b1, 32'd0};
    bt = (b == 8) ? 32'd0 : rf[b[2:0]];
    it = (i == 8) ? 32'd0 : rf[i[2:0]];
    return {1'b0, bt + (it << s) + dext(l, d)};
  endfunction

  // drive one set, check result at the following negedge
  task automatic run(string req, logic [3:0] b, logic [3:0] i,
                     logic [1:0] s, logic [1:0] l, logic [31:0] d);
    logic [32:0] e;
    e = model(b, i, s, l, d);
    @(negedge clk);
    in_base_id = b; in_index_id = i; in_scale = s; in_disp_len = l; in_disp = d;
    in_valid = 1;
    @(negedge clk);
    in_valid = 0;
    chk({req, " valid"}, {63'd0, out_valid}, 64'd1);
    chk(req, {31'd0, out_illegal, out_ea}, {31'd0, e});
  endtask

  task automatic t_reset();
    chk("R7 reset valid", {63'd0, out_valid}, 64'd0);
    chk("R8 reset ready", {63'd0, in_ready}, 64'd1);
  endtask

  task automatic t_basic();
    run("R1 full form", 4'd2, 4'd1, 2'd2, 2'd3, 32'h0000_0010);
    run("R1 wrap", 4'd3, 4'd3, 2'd0, 2'd0, 32'd0);
    run("R1 wrap disp", 4'd5, 4'd8, 2'd0, 2'd1, 32'h0000_0008);
    run("R5 base sp legal", 4'd4, 4'd7, 2'd1, 2'd0, 32'd0);
  endtask

  task automatic t_scale();
    for (int s = 0; s < 4; s++)
      run($sformatf("R2 scale %0d", s), 4'd8, 4'd7, s[1:0], 2'd0, 32'd0);
  endtask

  task automatic t_disp();
    run("R3 b1 neg", 4'd8, 4'd8, 2'd0, 2'd1, 32'hAABB_CC80);
    run("R3 b1 pos", 4'd0, 4'd8, 2'd0, 2'd1, 32'hFFFF_FF7F);
    run("R3 b2 neg", 4'd8, 4'd8, 2'd0, 2'd2, 32'h1234_8001);
    run("R3 b4", 4'd8, 4'd8, 2'd0, 2'd3, 32'h0403_0201);
    @(negedge clk);
    chk("R3 le order", {32'd0, out_ea}, 64'h0000_0000_0403_0201);
  endtask

  task automatic t_none();
    run("R4 no index", 4'd6, 4'd8, 2'd3, 2'd0, 32'd0);
    run("R4 no base", 4'd8, 4'd6, 2'd1, 2'd0, 32'd0);
    run("R4 none none", 4'd8, 4'd8, 2'd3, 2'd0, 32'd0);
  endtask

  task automatic t_illegal();
    run("R5 sp index", 4'd0, 4'd4, 2'd0, 2'd3, 32'h10);
    run("R6 base 9", 4'd9, 4'd0, 2'd0, 2'd0, 32'd0);
    run("R6 index 15", 4'd0, 4'd15, 2'd0, 2'd3, 32'h5);
  endtask

  task automatic t_rfaddr();
    @(negedge clk);
    in_base_id = 4'd6; in_index_id = 4'd3;
    #1;
    chk("R9 base addr", {61'd0, rf_base_addr}, 64'd6);
    chk("R9 index addr", {61'd0, rf_index_addr}, 64'd3);
  endtask

  task automatic t_backpressure();
    logic [32:0] ea_a, ea_b;
    ea_a = model(4'd0, 4'd1, 2'd0, 2'd0, 32'd0);
    ea_b = model(4'd2, 4'd8, 2'd0, 2'd1, 32'h0000_00FF);
    @(negedge clk);
    out_ready = 0;
    in_base_id = 0; in_index_id = 1; in_scale = 0; in_disp_len = 0; in_disp = 0;
    in_valid = 1;
    @(negedge clk);
    in_base_id = 2; in_index_id = 8; in_disp_len = 1; in_disp = 32'hFF;
    chk("R8 stall ready", {63'd0, in_ready}, 64'd0);
    chk("R7 stalled valid", {63'd0, out_valid}, 64'd1);
    @(negedge clk);
    chk("R8 held", {31'd0, out_illegal, out_ea}, {31'd0, ea_a});
    out_ready = 1;
    #1;
    chk("R8 drain ready", {63'd0, in_ready}, 64'd1);
    @(negedge clk);
    in_valid = 0;
    chk("R8 next", {31'd0, out_illegal, out_ea}, {31'd0, ea_b});
    @(negedge clk);
    chk("R7 drained", {63'd0, out_valid}, 64'd0);
  endtask

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
    end
  end

  initial begin
    rf[0] = 32'h0000_1000; rf[1] = 32'h0000_0100; rf[2] = 32'h0000_F000;
    rf[3] = 32'h8000_0000; rf[4] = 32'h7FFF_FFF0; rf[5] = 32'hFFFF_FFFC;
    rf[6] = 32'h1234_5678; rf[7] = 32'h0000_0011;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    t_basic();
    t_scale();
    t_disp();
    t_none();
    t_illegal();
    t_rfaddr();
    t_backpressure();
    finish_run();
  end
endmodule